// File: doc/BRIEF.md
# Forwarding Register File

A multi-entry register file with one write port and two read ports whose data paths are combinational. A write presented in a cycle lands in the storage at the next rising clock edge. In that same cycle, any read port whose address matches the write address returns the incoming write data rather than the stale stored word. An update therefore appears ordered ahead of every read issued in that cycle.

The block lets a decode stage read operands in the same cycle that an execute stage commits a result. The decode stage sees the new value without an extra stall cycle and without holding a separate copy. When the addresses differ, or when no write is in progress, each port returns the stored entry. The two ports make their forwarding decisions independently of each other. The number of entries and the word width are parameters, with defaults of 32 entries of 32 bits. Entry 0 is an ordinary storage location.

Top module: `fwd_regfile`

## Requirements
- R1: While rst_ni is low, and after it is released, every entry reads as zero until that entry is written.
- R2: When we_i is 1 at a rising clock edge, wdata_i is stored at waddr_i. A read of that address in any later cycle returns that value until the entry is written again. This holds for every address, including 0 and NUM_REGS-1.
- R3: When we_i is 1 and ra_a_i equals waddr_i, rdata_a_o equals wdata_i in that same cycle, before the edge.
- R4: When we_i is 1 and ra_b_i equals waddr_i, rdata_b_o equals wdata_i in that same cycle, regardless of what port A addresses.
- R5: When we_i is 0, a read of an address equal to waddr_i returns the stored value, not wdata_i, and the edge leaves the storage unchanged.
- R6: When we_i is 1 and a read address differs from waddr_i, that port returns the stored value of the address it reads.
- R7: When both ports read the same address, they return the same word, whether it comes from the write port or from storage.
- R8: A write changes only the addressed entry. A second write to the same entry replaces the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears all entries |
| we_i | input | 1 | Write enable |
| waddr_i | input | ADDR_W | Write address |
| wdata_i | input | DATA_W | Write data |
| ra_a_i | input | ADDR_W | Read port A address |
| rdata_a_o | output | DATA_W | Read port A data |
| ra_b_i | input | ADDR_W | Read port B address |
| rdata_b_o | output | DATA_W | Read port B data |

## Verification
The bench builds the block with its default sizes, 32 entries of 32 bits, so the address compare is five bits wide. Entries 0 and 31 can be hit directly as boundary addresses. With 32-bit words, distinct patterns make a value that was wrongly forwarded or wrongly stored stand out from the stored word. Matching and non-matching addresses are placed on the two ports at the same time, which separates per-port forwarding from a shared select.

// File: rtl/fwd_rf_pkg.sv
package fwd_rf_pkg;
  typedef enum logic {
    SRC_STORE  = 1'b0,
    SRC_BYPASS = 1'b1
  } rd_src_e;

  localparam int unsigned NUM_RD_PORTS = 2;
endpackage

// File: rtl/fwd_rf_store.sv
module fwd_rf_store #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_RD   = 2,
  localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i [NUM_RD],
  output logic [DATA_W-1:0] rdata_o [NUM_RD]
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we_i && (32'(waddr_i) < NUM_REGS)) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // out-of-range addresses read zero when NUM_REGS is not a power of two
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    assign rdata_o[p] = (32'(raddr_i[p]) < NUM_REGS) ? mem_q[raddr_i[p]] : '0;
  end
endmodule

// File: rtl/fwd_rf_rdport.sv
module fwd_rf_rdport
  import fwd_rf_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  rd_src_e src;

  always_comb begin
    src = (we_i && (raddr_i == waddr_i)) ? SRC_BYPASS : SRC_STORE;
    unique case (src)
      SRC_BYPASS: rdata_o = wdata_i;
      default:    rdata_o = stored_i;
    endcase
  end
endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile
  import fwd_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] ra_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] ra_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [ADDR_W-1:0] raddr  [NUM_RD_PORTS];
  logic [DATA_W-1:0] stored [NUM_RD_PORTS];
  logic [DATA_W-1:0] rdata  [NUM_RD_PORTS];

  assign raddr[0]  = ra_a_i;
  assign raddr[1]  = ra_b_i;
  assign rdata_a_o = rdata[0];
  assign rdata_b_o = rdata[1];

  fwd_rf_store #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W),
    .NUM_RD  (NUM_RD_PORTS)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .waddr_i(waddr_i),
    .wdata_i(wdata_i),
    .raddr_i(raddr),
    .rdata_o(stored)
  );

  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_port
    fwd_rf_rdport #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_rdport (
      .raddr_i (raddr[p]),
      .stored_i(stored[p]),
      .we_i    (we_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata[p])
    );
  end
endmodule

// File: rtl/fwd_regfile_chk.sv
module fwd_regfile_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [ADDR_W-1:0] ra_a_i,
  input logic [DATA_W-1:0] rdata_a_o,
  input logic [ADDR_W-1:0] ra_b_i,
  input logic [DATA_W-1:0] rdata_b_o
);
  logic              last_we_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [DATA_W-1:0] last_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_we_q   <= 1'b0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else begin
      last_we_q   <= we_i;
      last_addr_q <= waddr_i;
      last_data_q <= wdata_i;
    end
  end

  // R3
  fwd_a_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (we_i && ra_a_i == waddr_i) |-> rdata_a_o == wdata_i);

  // R4
  fwd_b_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (we_i && ra_b_i == waddr_i) |-> rdata_b_o == wdata_i);

  // R2
  stored_a_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (last_we_q && ra_a_i == last_addr_q && !(we_i && waddr_i == last_addr_q))
      |-> rdata_a_o == last_data_q);

  // R2
  stored_b_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (last_we_q && ra_b_i == last_addr_q && !(we_i && waddr_i == last_addr_q))
      |-> rdata_b_o == last_data_q);

  // R7
  same_addr_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (ra_a_i == ra_b_i) |-> rdata_a_o == rdata_b_o);
endmodule

bind fwd_regfile fwd_regfile_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .waddr_i  (waddr_i),
  .wdata_i  (wdata_i),
  .ra_a_i   (ra_a_i),
  .rdata_a_o(rdata_a_o),
  .ra_b_i   (ra_b_i),
  .rdata_b_o(rdata_b_o)
);

// File: tb/tb_fwd_regfile.sv
`timescale 1ns/1ps
module tb_fwd_regfile;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              we_i = 1'b0;
  logic [ADDR_W-1:0] waddr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [ADDR_W-1:0] ra_a_i = '0;
  logic [ADDR_W-1:0] ra_b_i = '0;
  logic [DATA_W-1:0] rdata_a_o;
  logic [DATA_W-1:0] rdata_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  fwd_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .waddr_i(waddr_i),
    .wdata_i(wdata_i), .ra_a_i(ra_a_i), .rdata_a_o(rdata_a_o),
    .ra_b_i(ra_b_i), .rdata_b_o(rdata_b_o)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_rd(input int a, input int b);
    ra_a_i = ADDR_W'(a);
    ra_b_i = ADDR_W'(b);
    #1;
  endtask

  task automatic do_write(input int addr, input logic [DATA_W-1:0] data);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = ADDR_W'(addr); wdata_i = data;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    set_rd(0, 31);
    check("R1 port A entry 0", rdata_a_o, '0);
    check("R1 port B entry 31", rdata_b_o, '0);
    set_rd(17, 5);
    check("R1 port A entry 17", rdata_a_o, '0);
    check("R1 port B entry 5", rdata_b_o, '0);
  endtask

  task automatic t_store();
    do_write(5, 32'hA5A5_0005);
    do_write(0, 32'h0000_CAFE);
    do_write(31, 32'hFFFF_0031);
    set_rd(5, 0);
    check("R2 port A entry 5", rdata_a_o, 32'hA5A5_0005);
    check("R2 port B entry 0", rdata_b_o, 32'h0000_CAFE);
    set_rd(31, 31);
    check("R2 port A entry 31", rdata_a_o, 32'hFFFF_0031);
    check("R7 both ports stored", rdata_b_o, 32'hFFFF_0031);
  endtask

  task automatic t_bypass();
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 5'd7; wdata_i = 32'h1234_5678;
    set_rd(7, 5);
    check("R3 port A same cycle", rdata_a_o, 32'h1234_5678);
    check("R6 port B other addr", rdata_b_o, 32'hA5A5_0005);
    set_rd(0, 7);
    check("R6 port A other addr", rdata_a_o, 32'h0000_CAFE);
    check("R4 port B same cycle", rdata_b_o, 32'h1234_5678);
    set_rd(7, 7);
    check("R7 both forwarded A", rdata_a_o, 32'h1234_5678);
    check("R7 both forwarded B", rdata_b_o, 32'h1234_5678);
    @(negedge clk_i);
    we_i = 1'b0;
    #1;
    check("R2 forwarded value stored", rdata_a_o, 32'h1234_5678);
  endtask

  task automatic t_disabled();
    @(negedge clk_i);
    we_i = 1'b0; waddr_i = 5'd5; wdata_i = 32'hDEAD_BEEF;
    set_rd(5, 5);
    check("R5 no forward A", rdata_a_o, 32'hA5A5_0005);
    check("R5 no forward B", rdata_b_o, 32'hA5A5_0005);
    @(negedge clk_i);
    #1;
    check("R5 storage unchanged", rdata_a_o, 32'hA5A5_0005);
  endtask

  task automatic t_overwrite();
    do_write(5, 32'h5555_0001);
    do_write(5, 32'h5555_0002);
    set_rd(5, 6);
    check("R8 second write wins", rdata_a_o, 32'h5555_0002);
    check("R8 neighbour untouched", rdata_b_o, '0);
    set_rd(4, 7);
    check("R8 lower neighbour untouched", rdata_a_o, '0);
    check("R8 other entry kept", rdata_b_o, 32'h1234_5678);
    @(negedge clk_i);
    we_i = 1'b1; waddr_i = 5'd0; wdata_i = 32'h0BAD_0000;
    set_rd(0, 31);
    check("R3 forward entry 0", rdata_a_o, 32'h0BAD_0000);
    check("R6 entry 31 stored", rdata_b_o, 32'hFFFF_0031);
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic t_rereset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    set_rd(5, 31);
    check("R1 async clear A", rdata_a_o, '0);
    check("R1 async clear B", rdata_b_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    set_rd(7, 0);
    check("R1 cleared after release A", rdata_a_o, '0);
    check("R1 cleared after release B", rdata_b_o, '0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_store();
    t_bypass();
    t_disabled();
    t_overwrite();
    t_rereset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule